// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

The block turns single register-style requests from a host into timed bus cycles on an 8-bit NAND flash interface. A request names one of four kinds: command, address, data write and data read. A command request drives a write cycle with the command latch enable high. An address request drives a write cycle with the address latch enable high. A data request drives a plain write or read strobe. While a cycle is on the bus, the host request port holds its ready low. Read data comes back on a separate output with a one-cycle valid pulse.

One packed 26-bit timing word sets every part of a cycle. It gives the widths of the write-low, write-high, read-low and read-high phases, the idle turnaround used when the bus changes direction, the delay before the ready/busy pin is trusted, and the chip-enable setup time. Chip enable is either driven by the sequencer around each access or held at a level the host chooses. After each command cycle a NAND-ready status drops, and it rises again only once the busy delay has run out and the ready/busy pin reads high. A command byte of 0xFF also clears the sequencer's read-data register and its memory of the last bus direction.

Top module: `nand_cycle_gen`

## Requirements
- R1: Request kind 2'b00 is a command cycle. `nand_cle` is high and `nand_ale` is low for the whole cycle. `nand_we_n` is low for max(1, timing[3:0]) cycles and `nand_dq_o` carries the request byte while it is low.
- R2: Request kind 2'b01 is an address cycle. `nand_ale` is high and `nand_cle` is low for the whole cycle, with the same write strobe timing as R1.
- R3: Request kind 2'b10 is a data write. Neither latch enable is high, `nand_we_n` is low for max(1, timing[3:0]) cycles and high for max(1, timing[7:4]) cycles, and `nand_dq_oe` is high throughout.
- R4: Request kind 2'b11 is a data read. `nand_re_n` is low for max(1, timing[11:8]) cycles and then high for max(1, timing[15:12]) cycles. `nand_dq_oe` stays low. `nand_dq_i` is captured into `rd_data` in the last read-low cycle, and `rd_valid` pulses for one cycle.
- R5: A timing field of zero gives a phase of one clock cycle.
- R6: `req_ready` is high only when no cycle is in progress. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low for every cycle of the accepted access.
- R7: With `cfg_ce_auto`=1, `nand_ce_n` goes low max(1, timing[25:24]) cycles before the strobe phase and stays low through the high phase. It is high between accesses.
- R8: With `cfg_ce_auto`=0 there is no chip-enable setup phase, and `nand_ce_n` always equals the inverse of `cfg_ce_force`.
- R9: When a write-type access follows a read, or a read follows a write-type access, max(1, timing[18:16]) idle cycles are inserted first, with chip enable and strobes inactive. Between two accesses in the same direction, no idle cycles are inserted.
- R10: When a command cycle ends, `nand_ready` goes low. It rises only after max(1, timing[23:19]) cycles have passed and `nand_rb` is high, and it stays low for as long as `nand_rb` is low.
- R11: A command cycle with byte 0xFF clears `rd_data` to 0 and clears the direction history, so the next access gets no turnaround.
- R12: After reset, `req_ready` is 1, both strobes and `nand_ce_n` (auto mode) are 1, both latch enables are 0 and `nand_ready` is 0.
- R13: `nand_we_n` and `nand_re_n` are never low together, and `nand_cle` and `nand_ale` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_timing | input | 26 | Packed phase-width word |
| cfg_ce_auto | input | 1 | 1: sequencer drives chip enable around each access |
| cfg_ce_force | input | 1 | Chip-enable level requested when not automatic (1 = enabled) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, can accept a request |
| req_kind | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| req_wdata | input | 8 | Command, address or write byte |
| rd_data | output | 8 | Last byte read from the flash |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated by a read |
| nand_ready | output | 1 | Flash ready status after busy delay |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready/busy pin, high = ready |

## Verification
The hardest case to reach is the interaction of direction history with the 0xFF command: a read must come first, then a reset command, and only the length of the read that follows shows that the history was cleared. The bench runs that sequence, and then contrasts it with a read that follows an ordinary command and does get a turnaround. The busy status is tested by holding the ready/busy pin low well past the busy delay and then releasing it. Each access is measured by counting, at every falling clock edge, the cycles in which each strobe, latch enable and chip enable is active, and these counts are compared with the field values.

// File: rtl/nand_cg_pkg.sv
`timescale 1ns/1ps
package nand_cg_pkg;

    localparam int TIMING_W = 26;
    localparam int LEN_W    = 5;

    typedef enum logic [1:0] {
        K_CMD  = 2'b00,
        K_ADDR = 2'b01,
        K_WR   = 2'b10,
        K_RD   = 2'b11
    } kind_e;

    typedef enum logic [2:0] {
        P_IDLE,
        P_TURN,
        P_CESU,
        P_LOW,
        P_HIGH
    } phase_e;

    typedef enum logic [1:0] {
        D_NONE,
        D_WR,
        D_RD
    } dir_e;

    typedef struct packed {
        logic [LEN_W-1:0] wr_lo;
        logic [LEN_W-1:0] wr_hi;
        logic [LEN_W-1:0] rd_lo;
        logic [LEN_W-1:0] rd_hi;
        logic [LEN_W-1:0] turn;
        logic [LEN_W-1:0] busy;
        logic [LEN_W-1:0] ce_su;
    } lens_t;

    function automatic logic [LEN_W-1:0] at_least_one(input logic [LEN_W-1:0] v);
        return (v == '0) ? LEN_W'(1) : v;
    endfunction

endpackage

// File: rtl/nand_timing_decode.sv
`timescale 1ns/1ps
module nand_timing_decode
    import nand_cg_pkg::*;
(
    input  logic [TIMING_W-1:0] timing,
    output lens_t               lens
);
    // Field positions are fixed by the timing word layout.
    always_comb begin
        lens.wr_lo = at_least_one(LEN_W'(timing[3:0]));
        lens.wr_hi = at_least_one(LEN_W'(timing[7:4]));
        lens.rd_lo = at_least_one(LEN_W'(timing[11:8]));
        lens.rd_hi = at_least_one(LEN_W'(timing[15:12]));
        lens.turn  = at_least_one(LEN_W'(timing[18:16]));
        lens.busy  = at_least_one(LEN_W'(timing[23:19]));
        lens.ce_su = at_least_one(LEN_W'(timing[25:24]));
    end
endmodule

// File: rtl/nand_busy_mon.sv
`timescale 1ns/1ps
module nand_busy_mon
    import nand_cg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] delay,
    input  logic             rb,
    output logic             ready
);
    typedef struct packed {
        logic             ready;
        logic             waiting;
        logic [LEN_W-1:0] cnt;
    } bm_t;

    bm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.ready   = 1'b0;
            st_d.waiting = 1'b1;
            st_d.cnt     = delay - LEN_W'(1);
        end else if (st_q.waiting) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - LEN_W'(1);
            end else if (rb) begin
                st_d.ready   = 1'b1;
                st_d.waiting = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ready: 1'b0, waiting: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;
endmodule

// File: rtl/nand_strobe_seq.sv
`timescale 1ns/1ps
module nand_strobe_seq
    import nand_cg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lens_t         lens,
    input  logic          ce_auto,
    input  logic          ce_force,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          cmd_done,
    output logic          ce_n,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    input  logic [DW-1:0] dq_i
);
    localparam logic [DW-1:0] RESET_CMD = {DW{1'b1}};

    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] cnt;
        kind_e            kind;
        logic [DW-1:0]    wdata;
        dir_e             dir;
        logic [DW-1:0]    rdata;
        logic             rvalid;
    } seq_t;

    seq_t st_d, st_q;

    kind_e            new_kind;
    logic             new_is_rd;
    logic             need_turn;
    logic [LEN_W-1:0] new_lo;
    logic [LEN_W-1:0] cur_lo;
    logic [LEN_W-1:0] cur_hi;
    logic             cur_is_rd;

    always_comb begin
        new_kind  = kind_e'(req_kind);
        new_is_rd = (new_kind == K_RD);
        need_turn = ((st_q.dir == D_RD) && !new_is_rd) ||
                    ((st_q.dir == D_WR) && new_is_rd);
        new_lo    = new_is_rd ? lens.rd_lo : lens.wr_lo;
        cur_is_rd = (st_q.kind == K_RD);
        cur_lo    = cur_is_rd ? lens.rd_lo : lens.wr_lo;
        cur_hi    = cur_is_rd ? lens.rd_hi : lens.wr_hi;
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        cmd_done    = 1'b0;
        unique case (st_q.phase)
            P_IDLE: begin
                if (req_valid) begin
                    st_d.kind  = new_kind;
                    st_d.wdata = req_wdata;
                    st_d.dir   = new_is_rd ? D_RD : D_WR;
                    if (need_turn) begin
                        st_d.phase = P_TURN;
                        st_d.cnt   = lens.turn - LEN_W'(1);
                    end else if (ce_auto) begin
                        st_d.phase = P_CESU;
                        st_d.cnt   = lens.ce_su - LEN_W'(1);
                    end else begin
                        st_d.phase = P_LOW;
                        st_d.cnt   = new_lo - LEN_W'(1);
                    end
                end
            end
            P_TURN: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - LEN_W'(1);
                end else if (ce_auto) begin
                    st_d.phase = P_CESU;
                    st_d.cnt   = lens.ce_su - LEN_W'(1);
                end else begin
                    st_d.phase = P_LOW;
                    st_d.cnt   = cur_lo - LEN_W'(1);
                end
            end
            P_CESU: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - LEN_W'(1);
                end else begin
                    st_d.phase = P_LOW;
                    st_d.cnt   = cur_lo - LEN_W'(1);
                end
            end
            P_LOW: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - LEN_W'(1);
                end else begin
                    st_d.phase = P_HIGH;
                    st_d.cnt   = cur_hi - LEN_W'(1);
                    if (cur_is_rd) begin
                        st_d.rdata  = dq_i;
                        st_d.rvalid = 1'b1;
                    end
                end
            end
            P_HIGH: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - LEN_W'(1);
                end else begin
                    st_d.phase = P_IDLE;
                    if (st_q.kind == K_CMD) begin
                        cmd_done = 1'b1;
                        if (st_q.wdata == RESET_CMD) begin
                            st_d.dir   = D_NONE;
                            st_d.rdata = '0;
                        end
                    end
                end
            end
            default: st_d.phase = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: P_IDLE, cnt: '0, kind: K_CMD, wdata: '0,
                      dir: D_NONE, rdata: '0, rvalid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    logic active;

    always_comb begin
        active    = (st_q.phase == P_CESU) || (st_q.phase == P_LOW) ||
                    (st_q.phase == P_HIGH);
        req_ready = (st_q.phase == P_IDLE);
        cle       = active && (st_q.kind == K_CMD);
        ale       = active && (st_q.kind == K_ADDR);
        we_n      = !((st_q.phase == P_LOW) && !cur_is_rd);
        re_n      = !((st_q.phase == P_LOW) && cur_is_rd);
        dq_oe     = active && !cur_is_rd;
        dq_o      = st_q.wdata;
        ce_n      = ce_auto ? !active : !ce_force;
        rd_data   = st_q.rdata;
        rd_valid  = st_q.rvalid;
    end
endmodule

// File: rtl/nand_cycle_gen.sv
`timescale 1ns/1ps
module nand_cycle_gen
    import nand_cg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TIMING_W-1:0] cfg_timing,
    input  logic                cfg_ce_auto,
    input  logic                cfg_ce_force,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_kind,
    input  logic [DW-1:0]       req_wdata,
    output logic [DW-1:0]       rd_data,
    output logic                rd_valid,
    output logic                nand_ready,
    output logic                nand_ce_n,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic [DW-1:0]       nand_dq_o,
    output logic                nand_dq_oe,
    input  logic [DW-1:0]       nand_dq_i,
    input  logic                nand_rb
);
    lens_t lens;
    logic  cmd_done;

    nand_timing_decode u_dec (
        .timing (cfg_timing),
        .lens   (lens)
    );

    nand_strobe_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .lens      (lens),
        .ce_auto   (cfg_ce_auto),
        .ce_force  (cfg_ce_force),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .cmd_done  (cmd_done),
        .ce_n      (nand_ce_n),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .dq_o      (nand_dq_o),
        .dq_oe     (nand_dq_oe),
        .dq_i      (nand_dq_i)
    );

    nand_busy_mon u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd_done),
        .delay (lens.busy),
        .rb    (nand_rb),
        .ready (nand_ready)
    );
endmodule

// File: rtl/nand_cycle_gen_chk.sv
`timescale 1ns/1ps
module nand_cycle_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rd_valid,
    input logic nand_ready,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe,
    input logic nand_rb
);
    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R13
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !req_ready);

    // R4
    rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!nand_re_n));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R4
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    // R10
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_ready) |-> $past(nand_rb));
endmodule

bind nand_cycle_gen nand_cycle_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .nand_ready (nand_ready),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .nand_rb    (nand_rb)
);

// File: tb/sim_nand_cycle_gen.sv
`timescale 1ns/1ps
module sim_nand_cycle_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [25:0] cfg_timing = '0;
    logic        cfg_ce_auto = 1'b1;
    logic        cfg_ce_force = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        nand_ready;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb = 1'b0;

    int checks = 0;
    int errors = 0;

    // measured per access
    int c_total, c_we, c_re, c_cle, c_ale, c_ce, c_oe, c_rdv, c_dqbad;

    always #10 clk = ~clk;

    nand_cycle_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
        .cfg_ce_auto(cfg_ce_auto), .cfg_ce_force(cfg_ce_force),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .nand_ready(nand_ready), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb(nand_rb)
    );

    function automatic logic [25:0] pack_t(int wl, int wh, int rl, int rh,
                                           int ta, int bz, int ce);
        return {ce[1:0], bz[4:0], ta[2:0], rh[3:0], rl[3:0], wh[3:0], wl[3:0]};
    endfunction

    function automatic int mx1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] kind, input logic [7:0] data);
        c_total = 0; c_we = 0; c_re = 0; c_cle = 0; c_ale = 0;
        c_ce = 0; c_oe = 0; c_rdv = 0; c_dqbad = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) begin
            c_total++;
            if (!nand_we_n) begin
                c_we++;
                if (nand_dq_o != data) c_dqbad++;
            end
            if (!nand_re_n) c_re++;
            if (nand_cle)   c_cle++;
            if (nand_ale)   c_ale++;
            if (!nand_ce_n) c_ce++;
            if (nand_dq_oe) c_oe++;
            if (rd_valid)   c_rdv++;
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        check("R12", "req_ready", int'(req_ready), 1);
        check("R12", "we_n", int'(nand_we_n), 1);
        check("R12", "re_n", int'(nand_re_n), 1);
        check("R12", "ce_n", int'(nand_ce_n), 1);
        check("R12", "cle|ale", int'(nand_cle | nand_ale), 0);
        check("R12", "nand_ready", int'(nand_ready), 0);
    endtask

    task automatic test_cmd();
        int n;
        access(2'b00, 8'h80);
        check("R1", "cle cycles", c_cle, 6);
        check("R1", "ale cycles", c_ale, 0);
        check("R1", "we low", c_we, 3);
        check("R1", "dq mismatches", c_dqbad, 0);
        check("R6", "busy cycles", c_total, 6);
        check("R7", "ce low cycles", c_ce, 6);
        n = 0;
        while (!nand_ready && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R10", "ready low cycles rb high", n, 5);
    endtask

    task automatic test_busy_hold();
        nand_rb = 1'b0;
        access(2'b00, 8'h70);
        repeat (20) @(negedge clk);
        check("R10", "ready while rb low", int'(nand_ready), 0);
        nand_rb = 1'b1;
        @(negedge clk);
        check("R10", "ready after rb high", int'(nand_ready), 1);
    endtask

    task automatic test_addr_write();
        access(2'b01, 8'h12);
        check("R2", "ale cycles", c_ale, 6);
        check("R2", "cle cycles", c_cle, 0);
        check("R2", "we low", c_we, 3);
        check("R9", "no turn same dir", c_total, 6);
        access(2'b10, 8'hA5);
        check("R3", "latch cycles", c_cle + c_ale, 0);
        check("R3", "we low", c_we, 3);
        check("R3", "oe cycles", c_oe, 6);
        check("R3", "dq mismatches", c_dqbad, 0);
    endtask

    task automatic test_read_turn();
        nand_dq_i = 8'h3C;
        access(2'b11, 8'h00);
        check("R9", "turn write->read total", c_total, 8);
        check("R9", "ce low excludes turn", c_ce, 6);
        check("R4", "re low", c_re, 4);
        check("R4", "oe cycles", c_oe, 0);
        check("R4", "rd_valid pulses", c_rdv, 1);
        check("R4", "rd_data", int'(rd_data), 8'h3C);
        nand_dq_i = 8'hC3;
        access(2'b11, 8'h00);
        check("R9", "read->read total", c_total, 6);
        check("R4", "rd_data second", int'(rd_data), 8'hC3);
        access(2'b10, 8'h5A);
        check("R9", "turn read->write total", c_total, 8);
    endtask

    task automatic test_zero_fields();
        cfg_timing = '0;
        access(2'b10, 8'h11);
        check("R5", "we low zero field", c_we, 1);
        check("R5", "total zero fields", c_total, 3);
        access(2'b11, 8'h00);
        check("R5", "total read zero fields", c_total, 4);
        check("R5", "re low zero field", c_re, 1);
    endtask

    task automatic test_forced_ce();
        cfg_timing   = pack_t(3, 2, 4, 1, 2, 5, 1);
        cfg_ce_auto  = 1'b0;
        cfg_ce_force = 1'b1;
        @(negedge clk);
        check("R8", "ce_n idle forced on", int'(nand_ce_n), 0);
        access(2'b11, 8'h00);
        check("R8", "no setup phase total", c_total, 5);
        check("R8", "ce low all cycles", c_ce, 5);
        cfg_ce_force = 1'b0;
        access(2'b11, 8'h00);
        check("R8", "ce low when forced off", c_ce, 0);
        cfg_ce_auto = 1'b1;
    endtask

    task automatic test_reset_cmd();
        nand_dq_i = 8'h99;
        access(2'b11, 8'h00);
        check("R4", "rd_data before 0xFF", int'(rd_data), 8'h99);
        access(2'b00, 8'hFF);
        check("R11", "0xFF after read has turn", c_total, 8);
        check("R11", "rd_data cleared", int'(rd_data), 0);
        access(2'b11, 8'h00);
        check("R11", "read after 0xFF no turn", c_total, 6);
        access(2'b00, 8'h30);
        access(2'b11, 8'h00);
        check("R9", "read after plain cmd turn", c_total, 8);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        cfg_timing = pack_t(3, 2, 4, 1, 2, 5, 1);
        nand_rb = 1'b1;
        repeat (3) @(negedge clk);
        test_cmd();
        test_busy_hold();
        test_addr_write();
        test_read_turn();
        test_zero_fields();
        test_forced_ce();
        test_reset_cmd();
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule